// File: doc/BRIEF.md
# Protected-Mode Segment Translation Unit

This block holds six segment registers, each with a visible 16-bit selector and a hidden cache of base, limit and access rights. It serves two operations. A segment load takes a selector and fetches the 64-bit descriptor that the selector points to over a simple read handshake. It then applies the privilege rule and, if the rule passes, fills the hidden cache of the target register. A translation takes a register index and an offset, compares the offset against the cached limit, and returns the cached base plus the offset. No memory is read during a translation.

Privilege is checked only when a register is loaded. The current privilege level is taken from the low two bits of the selector cached in the code register. A parameter picks between a narrow configuration (24-bit base, 16-bit offset and limit) and a wide one (32-bit base, 32-bit offset, 20-bit limit zero-extended). A translation aimed at the register that is being loaded is held off until the load finishes. Translations to any other register go ahead meanwhile.

Top module: `seg_xlate_unit`

## Requirements
- R1: A selector carries the requested level in bits 1:0, the table choice in bit 2 (0 = global table base, 1 = local table base) and the descriptor index in bits 15:3. The descriptor read address is the chosen table base plus index × 8, modulo the base width. It stays stable on `mrd_addr` with `mrd_req` high until `mrd_ack`.
- R2: The descriptor fields are: limit in bits 15:0 (wide mode adds bits 51:48 above them), base in bits 39:16 (wide mode adds bits 63:56 above them), access rights in bits 47:40, and descriptor privilege level (DPL) in bits 46:45.
- R3: A load succeeds only when max(CPL, RPL) ≤ DPL. CPL is bits 1:0 of the selector cached in register 0 (code), and levels run from 0 (most privileged) to 3.
- R4: A failed load gives a one-cycle `ld_fault` pulse with the offending selector on `ld_fault_sel`. The target register's cache is left unchanged.
- R5: After `mrd_ack`, the unit spends one cycle checking and one cycle filling. `ld_done` pulses during the fill cycle, and translations from the next cycle use the new contents. A new load is accepted only while `ld_busy` is low. A load request made while busy is ignored.
- R6: An accepted translation gives, one cycle later, `xl_valid` high with `xl_lin` = (base + offset) modulo 2^base width. The register's selector and access rights appear on `xl_sel` and `xl_acc`.
- R7: A translation whose offset exceeds the cached limit gives `xl_gp` high and `xl_lin` zero.
- R8: Register indices 6 and 7 do not exist. A translation to one of them faults, and a load to one of them ends with `ld_fault`.
- R9: A translation to the register whose load is in progress sees `xl_stall` high and produces no result. A translation to another register completes normally during the load.
- R10: Reset leaves every selector and base at zero, every limit at all ones, `ld_busy` low and `xl_valid` low.

Ports: the first table column is the port name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_tbl_base | input | BASE_W | Global descriptor table base |
| loc_tbl_base | input | BASE_W | Local descriptor table base |
| ld_req | input | 1 | Load request |
| ld_seg | input | 3 | Register index to load |
| ld_sel | input | 16 | Selector to load |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | Load completed strobe |
| ld_fault | output | 1 | Load refused strobe |
| ld_fault_sel | output | 16 | Selector of the refused load |
| mrd_req | output | 1 | Descriptor read request |
| mrd_addr | output | BASE_W | Descriptor read address |
| mrd_ack | input | 1 | Read data valid |
| mrd_data | input | 64 | Descriptor data |
| xl_req | input | 1 | Translation request |
| xl_seg | input | 3 | Register index to translate through |
| xl_off | input | OFF_W | Offset |
| xl_stall | output | 1 | Request held off this cycle |
| xl_valid | output | 1 | Translation result valid |
| xl_lin | output | BASE_W | Linear address |
| xl_gp | output | 1 | General-protection fault on translation |
| xl_sel | output | 16 | Selector of the register used |
| xl_acc | output | 8 | Access rights of the register used |

## Verification
A descriptor load and a translation can be under way in the same cycle. The interesting case is when both address one register. The bench starts a load with a slow memory reply and, during it, issues a translation to the same register; that request must stall and yield nothing. A translation to a different register must complete with the old cached values. The held request is then judged after the fill, and its result must carry the newly loaded base.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int NUM_SEG   = 6;
  localparam int SEG_IDX_W = 3;
  localparam int SEL_W     = 16;
  localparam int DESC_W    = 64;
  localparam int PL_W      = 2;
  localparam int ACC_W     = 8;
  localparam int CODE_SEG  = 0;
  localparam logic [SEG_IDX_W-1:0] LAST_SEG = SEG_IDX_W'(NUM_SEG - 1);

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_READ,
    LD_CHECK,
    LD_FILL
  } ld_state_e;
endpackage

// File: rtl/seg_load_fsm.sv
module seg_load_fsm
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 24,
  parameter int OFF_W  = 16,
  parameter bit WIDE   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BASE_W-1:0]    glob_tbl_base,
  input  logic [BASE_W-1:0]    loc_tbl_base,
  input  logic [PL_W-1:0]      cpl,
  input  logic                 ld_req,
  input  logic [SEG_IDX_W-1:0] ld_seg,
  input  logic [SEL_W-1:0]     ld_sel,
  output logic                 ld_busy,
  output logic                 ld_done,
  output logic                 ld_fault,
  output logic [SEL_W-1:0]     ld_fault_sel,
  output logic                 mrd_req,
  output logic [BASE_W-1:0]    mrd_addr,
  input  logic                 mrd_ack,
  input  logic [DESC_W-1:0]    mrd_data,
  output logic [SEG_IDX_W-1:0] busy_seg,
  output logic                 wr_en,
  output logic [SEG_IDX_W-1:0] wr_idx,
  output logic [SEL_W-1:0]     wr_sel,
  output logic [BASE_W-1:0]    wr_base,
  output logic [OFF_W-1:0]     wr_limit,
  output logic [ACC_W-1:0]     wr_acc
);
  ld_state_e             state_q, state_d;
  logic [SEL_W-1:0]      sel_q;
  logic [SEG_IDX_W-1:0]  seg_q;
  logic [DESC_W-1:0]     desc_q;
  logic                  take_req, take_desc;
  logic [PL_W-1:0]       rpl, dpl, eff_pl;
  logic                  priv_ok;
  logic [BASE_W-1:0]     tbl_base;

  assign take_req  = (state_q == LD_IDLE) && ld_req;
  assign take_desc = (state_q == LD_READ) && mrd_ack;

  // privilege rule on the latched selector and fetched descriptor
  assign rpl     = sel_q[1:0];
  assign dpl     = desc_q[46:45];
  assign eff_pl  = (cpl > rpl) ? cpl : rpl;
  assign priv_ok = (eff_pl <= dpl) && (seg_q <= LAST_SEG);

  always_comb begin
    state_d = state_q;
    case (state_q)
      LD_IDLE:  if (ld_req)  state_d = LD_READ;
      LD_READ:  if (mrd_ack) state_d = LD_CHECK;
      LD_CHECK: state_d = priv_ok ? LD_FILL : LD_IDLE;
      LD_FILL:  state_d = LD_IDLE;
      default:  state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      seg_q  <= '0;
      desc_q <= '0;
    end else begin
      if (take_req) begin
        sel_q <= ld_sel;
        seg_q <= ld_seg;
      end
      if (take_desc) desc_q <= mrd_data;
    end
  end

  assign tbl_base = sel_q[2] ? loc_tbl_base : glob_tbl_base;
  assign mrd_addr = tbl_base + BASE_W'({sel_q[15:3], 3'b000});
  assign mrd_req  = (state_q == LD_READ);

  assign ld_busy      = (state_q != LD_IDLE);
  assign ld_done      = (state_q == LD_FILL);
  assign ld_fault     = (state_q == LD_CHECK) && !priv_ok;
  assign ld_fault_sel = sel_q;
  assign busy_seg     = seg_q;

  assign wr_en  = (state_q == LD_FILL);
  assign wr_idx = seg_q;
  assign wr_sel = sel_q;
  assign wr_acc = desc_q[47:40];

  generate
    if (WIDE) begin : g_wide
      logic unused_flags;
      assign unused_flags = ^desc_q[55:52];
      assign wr_base  = BASE_W'({desc_q[63:56], desc_q[39:16]});
      assign wr_limit = OFF_W'({desc_q[51:48], desc_q[15:0]});
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^desc_q[63:48];
      assign wr_base  = BASE_W'(desc_q[39:16]);
      assign wr_limit = OFF_W'(desc_q[15:0]);
    end
  endgenerate

  assert_hold_addr_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req && !mrd_ack |=> mrd_req && $stable(mrd_addr));

  assert_done_frees_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> !ld_busy);
endmodule

// File: rtl/seg_cache_file.sv
module seg_cache_file
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 24,
  parameter int OFF_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEG_IDX_W-1:0] wr_idx,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [BASE_W-1:0]    wr_base,
  input  logic [OFF_W-1:0]     wr_limit,
  input  logic [ACC_W-1:0]     wr_acc,
  input  logic [SEG_IDX_W-1:0] rd_idx,
  output logic                 rd_ok,
  output logic [SEL_W-1:0]     rd_sel,
  output logic [BASE_W-1:0]    rd_base,
  output logic [OFF_W-1:0]     rd_limit,
  output logic [ACC_W-1:0]     rd_acc,
  output logic [PL_W-1:0]      cpl
);
  localparam int SLOTS = 2 ** SEG_IDX_W;

  logic [SEL_W-1:0]  sel_a  [SLOTS];
  logic [BASE_W-1:0] base_a [SLOTS];
  logic [OFF_W-1:0]  lim_a  [SLOTS];
  logic [ACC_W-1:0]  acc_a  [SLOTS];

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < NUM_SEG) begin : g_live
        logic              hit;
        logic [SEL_W-1:0]  sel_r;
        logic [BASE_W-1:0] base_r;
        logic [OFF_W-1:0]  lim_r;
        logic [ACC_W-1:0]  acc_r;
        assign hit = wr_en && (wr_idx == SEG_IDX_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sel_r  <= '0;
            base_r <= '0;
            lim_r  <= '1;
            acc_r  <= '0;
          end else if (hit) begin
            sel_r  <= wr_sel;
            base_r <= wr_base;
            lim_r  <= wr_limit;
            acc_r  <= wr_acc;
          end
        end
        assign sel_a[i]  = sel_r;
        assign base_a[i] = base_r;
        assign lim_a[i]  = lim_r;
        assign acc_a[i]  = acc_r;
      end else begin : g_none
        assign sel_a[i]  = '0;
        assign base_a[i] = '0;
        assign lim_a[i]  = '0;
        assign acc_a[i]  = '0;
      end
    end
  endgenerate

  assign rd_ok    = (rd_idx <= LAST_SEG);
  assign rd_sel   = sel_a[rd_idx];
  assign rd_base  = base_a[rd_idx];
  assign rd_limit = lim_a[rd_idx];
  assign rd_acc   = acc_a[rd_idx];
  assign cpl      = sel_a[CODE_SEG][1:0];

  assert_fill_slot_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx <= LAST_SEG);
endmodule

// File: rtl/seg_addr_path.sv
module seg_addr_path
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 24,
  parameter int OFF_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xl_req,
  input  logic [SEG_IDX_W-1:0] xl_seg,
  input  logic [OFF_W-1:0]     xl_off,
  input  logic                 ld_busy,
  input  logic [SEG_IDX_W-1:0] busy_seg,
  output logic [SEG_IDX_W-1:0] rd_idx,
  input  logic                 rd_ok,
  input  logic [SEL_W-1:0]     rd_sel,
  input  logic [BASE_W-1:0]    rd_base,
  input  logic [OFF_W-1:0]     rd_limit,
  input  logic [ACC_W-1:0]     rd_acc,
  output logic                 xl_stall,
  output logic                 xl_valid,
  output logic [BASE_W-1:0]    xl_lin,
  output logic                 xl_gp,
  output logic [SEL_W-1:0]     xl_sel,
  output logic [ACC_W-1:0]     xl_acc
);
  logic              accept, fault;
  logic [BASE_W-1:0] sum;

  assign rd_idx   = xl_seg;
  assign xl_stall = xl_req && ld_busy && (xl_seg == busy_seg);
  assign accept   = xl_req && !xl_stall;
  assign fault    = !rd_ok || (xl_off > rd_limit);
  assign sum      = rd_base + BASE_W'(xl_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xl_valid <= 1'b0;
    else        xl_valid <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_lin <= '0;
      xl_gp  <= 1'b0;
      xl_sel <= '0;
      xl_acc <= '0;
    end else if (accept) begin
      xl_lin <= fault ? '0 : sum;
      xl_gp  <= fault;
      xl_sel <= rd_sel;
      xl_acc <= rd_acc;
    end
  end

  assert_stall_blocks_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    xl_req && xl_stall |=> !xl_valid);

  assert_bad_index_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    xl_req && !xl_stall && (xl_seg > LAST_SEG) |=> xl_valid && xl_gp);

  assert_gp_clears_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && xl_gp |-> xl_lin == '0);
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter  bit WIDE   = 1'b0,
  localparam int BASE_W = WIDE ? 32 : 24,
  localparam int OFF_W  = WIDE ? 32 : 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] glob_tbl_base,
  input  logic [BASE_W-1:0] loc_tbl_base,
  input  logic              ld_req,
  input  logic [2:0]        ld_seg,
  input  logic [15:0]       ld_sel,
  output logic              ld_busy,
  output logic              ld_done,
  output logic              ld_fault,
  output logic [15:0]       ld_fault_sel,
  output logic              mrd_req,
  output logic [BASE_W-1:0] mrd_addr,
  input  logic              mrd_ack,
  input  logic [63:0]       mrd_data,
  input  logic              xl_req,
  input  logic [2:0]        xl_seg,
  input  logic [OFF_W-1:0]  xl_off,
  output logic              xl_stall,
  output logic              xl_valid,
  output logic [BASE_W-1:0] xl_lin,
  output logic              xl_gp,
  output logic [15:0]       xl_sel,
  output logic [7:0]        xl_acc
);
  logic                 rst_meta_q, rst_sync_q;
  logic [PL_W-1:0]      cpl;
  logic [SEG_IDX_W-1:0] busy_seg, rd_idx;
  logic                 wr_en, rd_ok;
  logic [SEG_IDX_W-1:0] wr_idx;
  logic [SEL_W-1:0]     wr_sel, rd_sel;
  logic [BASE_W-1:0]    wr_base, rd_base;
  logic [OFF_W-1:0]     wr_limit, rd_limit;
  logic [ACC_W-1:0]     wr_acc, rd_acc;

  // reset asserts at once, leaves two clocks after the pin rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seg_load_fsm #(.BASE_W(BASE_W), .OFF_W(OFF_W), .WIDE(WIDE)) u_load (
    .clk(clk), .rst_n(rst_sync_q),
    .glob_tbl_base(glob_tbl_base), .loc_tbl_base(loc_tbl_base), .cpl(cpl),
    .ld_req(ld_req), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault),
    .ld_fault_sel(ld_fault_sel),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
    .busy_seg(busy_seg), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_acc(wr_acc)
  );

  seg_cache_file #(.BASE_W(BASE_W), .OFF_W(OFF_W)) u_cache (
    .clk(clk), .rst_n(rst_sync_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_acc(wr_acc),
    .rd_idx(rd_idx), .rd_ok(rd_ok), .rd_sel(rd_sel), .rd_base(rd_base),
    .rd_limit(rd_limit), .rd_acc(rd_acc), .cpl(cpl)
  );

  seg_addr_path #(.BASE_W(BASE_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst_n(rst_sync_q),
    .xl_req(xl_req), .xl_seg(xl_seg), .xl_off(xl_off),
    .ld_busy(ld_busy), .busy_seg(busy_seg),
    .rd_idx(rd_idx), .rd_ok(rd_ok), .rd_sel(rd_sel), .rd_base(rd_base),
    .rd_limit(rd_limit), .rd_acc(rd_acc),
    .xl_stall(xl_stall), .xl_valid(xl_valid), .xl_lin(xl_lin), .xl_gp(xl_gp),
    .xl_sel(xl_sel), .xl_acc(xl_acc)
  );
endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] GLOB = 24'h010000;
  localparam logic [23:0] LOC  = 24'h200000;

  logic        clk, rst_n;
  logic        ld_req, ld_busy, ld_done, ld_fault;
  logic [2:0]  ld_seg;
  logic [15:0] ld_sel, ld_fault_sel;
  logic        mrd_req, mrd_ack;
  logic [23:0] mrd_addr;
  logic [63:0] mrd_data;
  logic        xl_req, xl_stall, xl_valid, xl_gp;
  logic [2:0]  xl_seg;
  logic [15:0] xl_off, xl_sel;
  logic [23:0] xl_lin;
  logic [7:0]  xl_acc;

  int n_chk = 0;
  int n_err = 0;

  logic [63:0] next_desc;
  int          mem_wait;
  int          wcnt;
  logic [23:0] seen_addr;

  logic [23:0] m_base [8];
  logic [15:0] m_lim  [8];
  logic [15:0] m_sel  [8];
  logic [7:0]  m_acc  [8];

  seg_xlate_unit u_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n), .glob_tbl_base(GLOB), .loc_tbl_base(LOC),
    .ld_req(ld_req), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_busy(ld_busy),
    .ld_done(ld_done), .ld_fault(ld_fault), .ld_fault_sel(ld_fault_sel),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
    .xl_req(xl_req), .xl_seg(xl_seg), .xl_off(xl_off), .xl_stall(xl_stall),
    .xl_valid(xl_valid), .xl_lin(xl_lin), .xl_gp(xl_gp), .xl_sel(xl_sel),
    .xl_acc(xl_acc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // descriptor memory: replies after mem_wait idle cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      mrd_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mrd_ack) begin
      mrd_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mrd_req) begin
      if (wcnt >= mem_wait) begin
        mrd_ack   <= 1'b1;
        mrd_data  <= next_desc;
        seen_addr <= mrd_addr;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic [23:0] base, input logic [15:0] lim,
                                           input logic [1:0] dpl);
    logic [63:0] d;
    d = '0;
    d[15:0]  = lim;
    d[39:16] = base;
    d[44:40] = 5'h12;
    d[46:45] = dpl;
    d[47]    = 1'b1;
    return d;
  endfunction

  task automatic do_xl(input logic [2:0] seg, input logic [15:0] off, input string tag);
    logic [23:0] e_lin;
    bit          e_gp;
    e_gp  = (seg > 3'd5) || (off > m_lim[seg]);
    e_lin = e_gp ? 24'h0 : (m_base[seg] + {8'h00, off});
    @(negedge clk);
    xl_req = 1'b1; xl_seg = seg; xl_off = off;
    @(negedge clk);
    xl_req = 1'b0;
    chk(xl_valid == 1'b1, {tag, " valid"}, xl_valid, 1);
    chk(xl_gp == e_gp, {tag, " gp"}, xl_gp, e_gp);
    chk(xl_lin == e_lin, {tag, " lin"}, xl_lin, e_lin);
    if (!e_gp) begin
      chk(xl_sel == m_sel[seg], {tag, " sel"}, xl_sel, m_sel[seg]);
      chk(xl_acc == m_acc[seg], {tag, " acc"}, xl_acc, m_acc[seg]);
    end
  endtask

  task automatic do_load(input logic [2:0] seg, input logic [15:0] sel, input logic [23:0] base,
                         input logic [15:0] lim, input logic [1:0] dpl, input int wt,
                         input string tag);
    logic [63:0] d;
    logic [1:0]  cpl, eff;
    bit          e_ok, got_done, got_fault;
    logic [15:0] fsel;
    logic [23:0] e_addr;
    d   = mk_desc(base, lim, dpl);
    cpl = m_sel[0][1:0];
    eff = (cpl > sel[1:0]) ? cpl : sel[1:0];
    e_ok = (seg <= 3'd5) && (eff <= dpl);
    e_addr = (sel[2] ? LOC : GLOB) + {8'h00, sel[15:3], 3'b000};
    next_desc = d; mem_wait = wt;
    got_done = 1'b0; got_fault = 1'b0; fsel = '0;
    @(negedge clk);
    ld_req = 1'b1; ld_seg = seg; ld_sel = sel;
    @(negedge clk);
    ld_req = 1'b0;
    for (int k = 0; k < 64; k++) begin
      if (ld_done || ld_fault) break;
      @(negedge clk);
    end
    got_done = ld_done; got_fault = ld_fault; fsel = ld_fault_sel;
    @(negedge clk);
    chk(seen_addr == e_addr, {tag, " R1 descriptor address"}, seen_addr, e_addr);
    chk(got_done == e_ok, {tag, " R3 done"}, got_done, e_ok);
    chk(got_fault == !e_ok, {tag, " R4 fault"}, got_fault, !e_ok);
    if (!e_ok) chk(fsel == sel, {tag, " R4 fault selector"}, fsel, sel);
    if (e_ok) begin
      m_base[seg] = base; m_lim[seg] = lim; m_sel[seg] = sel; m_acc[seg] = d[47:40];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [12:0] idx;
    bit          saw_done;
    rst_n = 1'b0; ld_req = 1'b0; ld_seg = '0; ld_sel = '0;
    xl_req = 1'b0; xl_seg = '0; xl_off = '0;
    next_desc = '0; mem_wait = 0;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_lim[i] = 16'hFFFF; m_sel[i] = '0; m_acc[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(ld_busy == 1'b0, "R10 busy after reset", ld_busy, 0);
    chk(mrd_req == 1'b0, "R10 no read after reset", mrd_req, 0);
    chk(xl_valid == 1'b0, "R10 no result after reset", xl_valid, 0);
    for (int s = 0; s < 8; s++) begin
      do_xl(3'(s), 16'h1234, "R10 R8 reset translate");
      do_xl(3'(s), 16'hFFFF, "R10 reset limit");
    end

    // R3 R2 R6 R7 privilege sweep
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int dp = 0; dp < 4; dp++) begin
          do_load(3'd0, {13'd1, 1'b0, 2'(c)}, 24'h000000, 16'hFFFF, 2'd3, 0, "R3 code load");
          idx = 13'(2 + c * 16 + r * 4 + dp);
          do_load(3'd1, {idx, 1'(r), 2'(r)}, 24'h100000 + 24'(idx) * 24'h1111,
                  16'h0100 + 16'(idx) * 16'd3, 2'(dp), idx % 3, "R3 R2 data load");
          do_xl(3'd1, m_lim[1], "R6 at limit");
          do_xl(3'd1, m_lim[1] + 16'd1, "R7 past limit");
        end

    // R6 wrap of the linear address
    do_load(3'd3, {13'd90, 1'b0, 2'd3}, 24'hFFFFF0, 16'hFFFF, 2'd3, 1, "R6 wrap load");
    do_xl(3'd3, 16'h0020, "R6 wrap");

    // R8 load to a missing register
    do_load(3'd6, {13'd91, 1'b0, 2'd3}, 24'h123456, 16'h00FF, 2'd3, 0, "R8 bad load");
    do_xl(3'd6, 16'h0001, "R8 bad translate");

    // R9 R5 load and translate in the same window
    next_desc = mk_desc(24'h0A0000, 16'h0FFF, 2'd3); mem_wait = 4;
    @(negedge clk);
    ld_req = 1'b1; ld_seg = 3'd2; ld_sel = {13'd92, 1'b1, 2'd3};
    @(negedge clk);
    ld_req = 1'b0;
    xl_req = 1'b1; xl_seg = 3'd2; xl_off = 16'h0005;
    #1;
    chk(xl_stall == 1'b1, "R9 stall same register", xl_stall, 1);
    @(negedge clk);
    chk(xl_valid == 1'b0, "R9 no result while stalled", xl_valid, 0);
    ld_req = 1'b1; ld_seg = 3'd5; ld_sel = {13'd93, 1'b0, 2'd3};
    xl_seg = 3'd4; xl_off = 16'h0040;
    #1;
    chk(xl_stall == 1'b0, "R9 other register not stalled", xl_stall, 0);
    @(negedge clk);
    ld_req = 1'b0;
    chk(xl_valid == 1'b1, "R9 other register served", xl_valid, 1);
    chk(xl_lin == m_base[4] + 24'h40, "R9 other register lin", xl_lin, m_base[4] + 24'h40);
    xl_seg = 3'd2; xl_off = 16'h0005;
    saw_done = 1'b0;
    for (int k = 0; k < 64; k++) begin
      #1;
      if (ld_done) saw_done = 1'b1;
      if (!xl_stall) break;
      @(negedge clk);
    end
    chk(saw_done == 1'b1, "R5 done while held", saw_done, 1);
    @(negedge clk);
    xl_req = 1'b0;
    m_base[2] = 24'h0A0000; m_lim[2] = 16'h0FFF; m_sel[2] = {13'd92, 1'b1, 2'd3};
    m_acc[2] = mk_desc(24'h0A0000, 16'h0FFF, 2'd3) >> 40;
    chk(seen_addr == LOC + 24'd736, "R1 local table address", seen_addr, LOC + 24'd736);
    chk(xl_valid == 1'b1, "R9 held request served", xl_valid, 1);
    chk(xl_lin == 24'h0A0005, "R5 new base after fill", xl_lin, 24'h0A0005);
    repeat (2) @(negedge clk);
    chk(ld_busy == 1'b0, "R5 request while busy ignored", ld_busy, 0);
    do_xl(3'd5, 16'h0010, "R5 ignored load left register");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule